// File: doc/BRIEF.md
# Trimmed Real-Time Clock with Alarm

This block keeps wall-clock time in whole seconds. A fast tick, qualified by a tick-enable input, feeds a programmable trim divider; each time the divider reaches its programmed terminal value it returns to zero and emits a one-cycle seconds event. That event advances a 32-bit seconds counter. In the same cycle, the counter's value from before the advance is compared with an alarm register.

A four-bit status register collects two sticky event flags. The alarm flag is set on a match, and the seconds flag is set on every seconds event. Each flag has its own enable bit and is only set while that enable is on. Each interrupt output is the AND of a flag and its enable.

Software reaches the four registers through a simple word port. The port has a register address, a write strobe, write data and combinational read data.

Top module: `rtc_trimmed_clock`

## Requirements
- R1: An internal 16-bit divider advances by one on each cycle with `tick_en` high and holds otherwise. On a qualified tick where it equals the trim value, it returns to zero and produces one seconds event, so an event occurs every trim+1 qualified ticks.
- R2: On each seconds event, the seconds counter (address 0) is compared with the alarm register (address 1) using its value before the event, and then increases by one.
- R3: Status bit 0 (alarm flag) is set on a match only while status bit 2 (alarm enable) is 1.
- R4: Status bit 1 (seconds flag) is set on a seconds event only while status bit 3 (seconds enable) is 1.
- R5: `irq_alarm` equals status bit 0 AND bit 2, and `irq_hz` equals status bit 1 AND bit 3.
- R6: Writing 1 to status bit 0 or bit 1 (address 3) clears that flag, and writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R7: Status bits 2 and 3 take the written value. A flag set in the cycle of a status write uses the enable value from before the write.
- R8: The seconds counter and the alarm register are 32-bit writable registers. The counter wraps from all-ones to zero. A counter write in the cycle of a seconds event wins over the increment.
- R9: Reset clears the divider, counter, alarm and status, and loads trim (address 2) with a nonzero default (0x7FFF). Only the low 16 bits of a trim write are kept, and trim reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Qualifies one fast tick in this cycle |
| reg_addr | input | 2 | Register select: 0 seconds, 1 alarm, 2 trim, 3 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_hz | output | 1 | Seconds interrupt |

## Verification
The bench goes after the alarm comparison edge. A design that compared the counter after its increment would raise the alarm one second late or miss it. It also forces a flag clear and a flag set into the same cycle; a design that let the clear win would lose an event. An enable that is written in the cycle of a matching event must not retroactively gate that event, and a counter write must override the simultaneous increment. The bench also checks the all-ones counter wrap, the trim+1 period with trim at zero and at two, the divider holding while the tick is absent, and the masking of the upper trim bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int FLAGS_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_SECONDS = 2'd0,
        REG_ALARM   = 2'd1,
        REG_TRIM    = 2'd2,
        REG_STATUS  = 2'd3
    } rtc_reg_e;

    // Bit order matches the status word: [3] hz_en [2] alarm_en [1] hz_flag [0] alarm_flag
    typedef struct packed {
        logic hz_en;
        logic alarm_en;
        logic hz_flag;
        logic alarm_flag;
    } rtc_status_t;

    typedef struct packed {
        logic              wr;
        rtc_reg_e          sel;
        logic [DATA_W-1:0] data;
    } rtc_wreq_t;

    function automatic logic [DATA_W-1:0] status_word(rtc_status_t s);
        return {{(DATA_W-FLAGS_W){1'b0}}, s};
    endfunction

    function automatic logic hit_reg(rtc_wreq_t req, rtc_reg_e which);
        return req.wr && (req.sel == which);
    endfunction

endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider
    import rtc_pkg::*;
#(
    parameter int TRIM_W = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              trim_we,
    input  logic [TRIM_W-1:0] trim_wdata,
    output logic [TRIM_W-1:0] trim_q,
    output logic              sec_pulse
);

    logic [TRIM_W-1:0] div_q;
    logic              at_end;

    assign at_end    = (div_q == trim_q);
    assign sec_pulse = tick_en && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick_en) begin
            div_q <= at_end ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= TRIM_RESET;
        end else if (trim_we) begin
            trim_q <= trim_wdata;
        end
    end

    assert_event_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> (div_q == '0));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(div_q));

endmodule

// File: rtl/rtc_second_counter.sv
module rtc_second_counter
    import rtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_pulse,
    input  logic             cnt_we,
    input  logic             alarm_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] alarm_q,
    output logic             alarm_hit
);

    // compare uses the value held before this event's increment
    assign alarm_hit = sec_pulse && (count_q == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_we) begin
            count_q <= wdata;
        end else if (sec_pulse) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= '0;
        end else if (alarm_we) begin
            alarm_q <= wdata;
        end
    end

    assert_increment_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && !cnt_we) |=> (count_q == $past(count_q) + 1'b1));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (count_q == $past(wdata)));

endmodule

// File: rtl/rtc_event_status.sv
module rtc_event_status
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sec_pulse,
    input  logic               alarm_hit,
    input  logic               st_we,
    input  logic [FLAGS_W-1:0] wdata,
    output rtc_status_t        status_q,
    output logic               irq_alarm,
    output logic               irq_hz
);

    rtc_status_t status_n;
    rtc_status_t wr_view;
    logic        set_alarm, set_hz;
    logic        clr_alarm, clr_hz;

    assign wr_view   = rtc_status_t'(wdata);
    assign set_alarm = alarm_hit && status_q.alarm_en;
    assign set_hz    = sec_pulse && status_q.hz_en;
    assign clr_alarm = st_we && wr_view.alarm_flag;
    assign clr_hz    = st_we && wr_view.hz_flag;

    always_comb begin
        status_n            = status_q;
        status_n.alarm_flag = set_alarm | (status_q.alarm_flag & ~clr_alarm);
        status_n.hz_flag    = set_hz    | (status_q.hz_flag    & ~clr_hz);
        if (st_we) begin
            status_n.alarm_en = wr_view.alarm_en;
            status_n.hz_en    = wr_view.hz_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= status_n;
        end
    end

    assign irq_alarm = status_q.alarm_flag & status_q.alarm_en;
    assign irq_hz    = status_q.hz_flag    & status_q.hz_en;

    assert_alarm_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q.alarm_flag) |-> $past(alarm_hit && status_q.alarm_en));

    assert_hz_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q.hz_flag) |-> $past(sec_pulse && status_q.hz_en));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && status_q.hz_en) |=> status_q.hz_flag);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (st_we && wdata[0] && !(alarm_hit && status_q.alarm_en)) |=> !status_q.alarm_flag);

    assert_irq_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
        (st_we && !wdata[3]) |=> !irq_hz);

endmodule

// File: rtl/rtc_trimmed_clock.sv
module rtc_trimmed_clock
    import rtc_pkg::*;
#(
    parameter int TRIM_W = 16,
    parameter logic [TRIM_W-1:0] TRIM_RESET = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_alarm,
    output logic              irq_hz
);

    rtc_wreq_t         req;
    logic              sec_pulse;
    logic              alarm_hit;
    logic [TRIM_W-1:0] trim_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] alarm_q;
    rtc_status_t       status_q;

    assign req.wr   = reg_wr;
    assign req.sel  = rtc_reg_e'(reg_addr);
    assign req.data = reg_wdata;

    rtc_tick_divider #(
        .TRIM_W    (TRIM_W),
        .TRIM_RESET(TRIM_RESET)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .trim_we   (hit_reg(req, REG_TRIM)),
        .trim_wdata(req.data[TRIM_W-1:0]),
        .trim_q    (trim_q),
        .sec_pulse (sec_pulse)
    );

    rtc_second_counter #(
        .CNT_W(DATA_W)
    ) u_sec (
        .clk      (clk),
        .rst      (rst),
        .sec_pulse(sec_pulse),
        .cnt_we   (hit_reg(req, REG_SECONDS)),
        .alarm_we (hit_reg(req, REG_ALARM)),
        .wdata    (req.data),
        .count_q  (count_q),
        .alarm_q  (alarm_q),
        .alarm_hit(alarm_hit)
    );

    rtc_event_status u_st (
        .clk      (clk),
        .rst      (rst),
        .sec_pulse(sec_pulse),
        .alarm_hit(alarm_hit),
        .st_we    (hit_reg(req, REG_STATUS)),
        .wdata    (req.data[FLAGS_W-1:0]),
        .status_q (status_q),
        .irq_alarm(irq_alarm),
        .irq_hz   (irq_hz)
    );

    always_comb begin
        unique case (req.sel)
            REG_SECONDS: reg_rdata = count_q;
            REG_ALARM:   reg_rdata = alarm_q;
            REG_TRIM:    reg_rdata = {{(DATA_W-TRIM_W){1'b0}}, trim_q};
            REG_STATUS:  reg_rdata = status_word(status_q);
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/test_rtc_trimmed_clock.sv
module test_rtc_trimmed_clock;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_alarm, irq_hz;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_trimmed_clock i_rtc_trimmed_clock (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_alarm(irq_alarm), .irq_hz(irq_hz)
    );

    // behavioural reference model
    logic [15:0] m_div, m_trim;
    logic [31:0] m_cnt, m_alarm;
    bit m_af, m_hf, m_ae, m_he;

    task automatic model_reset();
        m_div = 0; m_trim = 16'h7FFF; m_cnt = 0; m_alarm = 0;
        m_af = 0; m_hf = 0; m_ae = 0; m_he = 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit ev, match, wst;
            ev    = tick_en && (m_div == m_trim);
            match = ev && (m_cnt == m_alarm);
            if (tick_en) m_div = ev ? 16'd0 : m_div + 16'd1;
            wst = reg_wr && reg_addr == 2'd3;
            m_af = (match && m_ae) || (m_af && !(wst && reg_wdata[0]));
            m_hf = (ev && m_he)    || (m_hf && !(wst && reg_wdata[1]));
            if (wst) begin m_ae = reg_wdata[2]; m_he = reg_wdata[3]; end
            if (reg_wr && reg_addr == 2'd0) m_cnt = reg_wdata;
            else if (ev) m_cnt = m_cnt + 1;
            if (reg_wr && reg_addr == 2'd1) m_alarm = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_trim = reg_wdata[15:0];
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison just before each rising edge
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            logic [31:0] exp;
            check("R5 irq_alarm", {31'b0, irq_alarm}, {31'b0, m_af && m_ae});
            check("R5 irq_hz",    {31'b0, irq_hz},    {31'b0, m_hf && m_he});
            case (reg_addr)
                2'd0: exp = m_cnt;
                2'd1: exp = m_alarm;
                2'd2: exp = {16'b0, m_trim};
                default: exp = {28'b0, m_he, m_ae, m_hf, m_af};
            endcase
            check("R8/R9/R6 readback", reg_rdata, exp);
        end
    end

    task automatic drive(bit t, bit w, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        tick_en = t; reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) drive(1, 0, 2'd0, 0);
    endtask

    task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
        drive(0, 0, a, 0);
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        rd("R9 reset seconds", 2'd0, 32'h0);
        rd("R9 reset alarm",   2'd1, 32'h0);
        rd("R9 reset trim",    2'd2, 32'h7FFF);
        rd("R9 reset status",  2'd3, 32'h0);
        check("R5 reset irq", {30'b0, irq_alarm, irq_hz}, 32'h0);

        drive(0, 1, 2'd2, 32'd2);
        drive(0, 1, 2'd0, 32'd10);
        drive(0, 1, 2'd1, 32'd11);
        drive(0, 1, 2'd3, 32'hC);
        ticks(2);
        rd("R1 no event before trim+1 ticks", 2'd0, 32'd10);
        ticks(1);
        rd("R1 R2 event after three ticks", 2'd0, 32'd11);
        ticks(3);
        rd("R2 R3 R4 pre-increment match sets flags", 2'd3, 32'hF);
        check("R5 both irqs", {30'b0, irq_alarm, irq_hz}, 32'h3);
        rd("R2 counter advanced", 2'd0, 32'd12);

        drive(0, 1, 2'd3, 32'hF);
        rd("R6 write-one clears flags", 2'd3, 32'hC);
        check("R5 irqs low after clear", {30'b0, irq_alarm, irq_hz}, 32'h0);

        drive(0, 1, 2'd3, 32'h0);
        ticks(3);
        rd("R4 disabled seconds flag stays clear", 2'd3, 32'h0);

        drive(0, 1, 2'd1, 32'd13);
        ticks(2);
        drive(1, 1, 2'd3, 32'h4);
        rd("R7 enable written with event uses old value", 2'd3, 32'h4);
        rd("R7 counter still advanced", 2'd0, 32'd14);

        drive(0, 1, 2'd2, 32'd0);
        drive(0, 1, 2'd3, 32'h8);
        ticks(1);
        drive(1, 1, 2'd3, 32'hA);
        rd("R6 set wins over clear", 2'd3, 32'hA);

        drive(0, 1, 2'd0, 32'hFFFF_FFFF);
        ticks(1);
        rd("R8 counter wraps to zero", 2'd0, 32'h0);
        drive(1, 1, 2'd0, 32'd100);
        rd("R8 write wins over increment", 2'd0, 32'd100);
        repeat (4) drive(0, 0, 2'd0, 0);
        rd("R1 no advance without tick", 2'd0, 32'd100);

        drive(0, 1, 2'd2, 32'hABCD_0005);
        rd("R9 trim keeps low 16 bits", 2'd2, 32'h5);
        drive(0, 1, 2'd1, 32'hDEAD_BEEF);
        rd("R8 alarm full width", 2'd1, 32'hDEAD_BEEF);

        // mixed traffic checked by the per-cycle model
        for (int i = 0; i < 600; i++) begin
            logic [1:0] a;
            logic [31:0] d;
            a = 2'($urandom_range(0, 3));
            d = (a == 2'd2) ? 32'($urandom_range(0, 3)) :
                (a == 2'd3) ? 32'($urandom_range(0, 15)) : 32'($urandom_range(0, 6));
            drive(1'($urandom_range(0, 3) != 0), $urandom_range(0, 7) == 0, a, d);
        end
        drive(0, 0, 2'd0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule